// File: doc/BRIEF.md
# Closed Caption Line Inserter

This block places closed-caption byte pairs onto the caption line of each video field. A host deposits one byte pair per field parity into a per-field holding slot. A timing generator supplies a line-start strobe, the current line number and the field parity. When the caption line of an enabled field begins and vertical-blanking output is open, the block latches the pending pair for that field. It then emits a serial bit stream on `cc_level`. The stream is a clock run-in, a three-bit start pattern and the two data bytes. A downstream waveform stage turns this bit-level request into luminance.

Each field has a slot only one entry deep, so a pair written before its caption line goes out on that same line with no extra frame of delay. The pair is latched at the line start. After that the slot is empty again, and a line with nothing new carries the null pair 0x80, 0x80. A two-bit field-mode control picks which parities carry captions.

Top module: `cc_line_inserter`

## Requirements
- R1: After reset `cc_busy` and `cc_level` are 0 and both field slots are empty, so the first caption line of either parity carries 0x80, 0x80.
- R2: A `line_start` pulse with `field_even`=0, `line_num`=ODD_LINE (default 21), `field_mode[0]`=1 and `vbi_open`=1 starts an insertion: `cc_busy` is 1 from the cycle after the pulse.
- R3: A `line_start` pulse with `field_even`=1, `line_num`=EVEN_LINE (default 284), `field_mode[1]`=1 and `vbi_open`=1 starts an insertion the same way.
- R4: `field_mode` 00 disables insertion, 01 allows only the odd field and 10 only the even field. A pulse on any other line, or on the parity that is not enabled, starts nothing.
- R5: With `vbi_open`=0 no insertion starts and the pending pair for that field is kept for a later line.
- R6: An insertion sends 33 slots of BIT_CLKS clocks each (default 27), 891 clocks in all, with `cc_busy` high for exactly that span. Slots 0 to 13 alternate 1,0 starting with 1. Slots 14, 15 and 16 are 0, 0, 1. Slots 17 to 24 carry the first byte (`cap_wr_pair[7:0]`) LSB first, and slots 25 to 32 carry the second byte (`cap_wr_pair[15:8]`) LSB first.
- R7: A pair written to a field's slot goes out on the next insertion of that field and is consumed by it.
- R8: An insertion whose field slot is empty sends 0x80 as both bytes.
- R9: A write made while a line is being emitted, or in the same cycle as the starting `line_start`, does not alter that line and goes out on the next insertion of its field.
- R10: A `line_start` pulse while `cc_busy` is 1 is ignored, and the running line continues unchanged.
- R11: The two field slots are independent (`cap_wr_field` 0 = odd, 1 = even). A second write to the same slot before its line replaces the first.
- R12: `cc_level` is 0 whenever `cc_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_wr | input | 1 | Write strobe for a caption pair |
| cap_wr_field | input | 1 | Target slot of the write: 0 odd, 1 even |
| cap_wr_pair | input | 16 | Pair to write: [7:0] first byte, [15:8] second byte |
| field_mode | input | 2 | Field enable: bit 0 odd, bit 1 even |
| vbi_open | input | 1 | Vertical-blanking output open (not fully blanked) |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| line_num | input | LINE_W | Current line number from the timing generator |
| field_even | input | 1 | Current field parity: 0 odd, 1 even |
| cc_level | output | 1 | Serial caption bit request |
| cc_busy | output | 1 | High while a caption line is emitted |

## Verification
The assertions watch, on every cycle, that an insertion only begins after a strobe with blanking open and its field enabled, that it lasts exactly 891 clocks, that the level stays low while idle, that a start never arrives while busy, and how each slot holds a fresh write or falls back to null after a capture. The byte order, the LSB-first bit order, the run-in and start pattern, the one-deep consumption and the deferral of writes made during a line are only visible in the bench's scenarios. There, a behavioural model is compared with the outputs every clock, and decoded lines are compared with the pairs that were written.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int RUNIN_SLOTS = 14;
    localparam int START_SLOTS = 3;
    localparam int FRAME_SLOTS = RUNIN_SLOTS + START_SLOTS + 16;
    localparam logic [15:0] NULL_PAIR = 16'h8080;

    // Slot order, LSB first: run-in 1,0,..., start 0,0,1, first byte, second byte
    function automatic logic [FRAME_SLOTS-1:0] cc_frame(input logic [15:0] pair);
        return {pair[15:8], pair[7:0], 3'b100, 14'h1555};
    endfunction

    typedef struct packed {
        logic        valid;
        logic [15:0] data;
    } slot_t;
endpackage

// File: rtl/cc_pair_slot.sv
module cc_pair_slot
    import cc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_pair,
    input  logic        take,
    output logic [15:0] pair_out
);
    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (take) s_d.valid = 1'b0;
        if (wr_en) begin
            s_d.valid = 1'b1;
            s_d.data  = wr_pair;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pair_out = s_q.valid ? s_q.data : NULL_PAIR;

    assert_null_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> pair_out == NULL_PAIR);
    assert_write_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pair_out == $past(wr_pair));
endmodule

// File: rtl/cc_bit_shifter.sv
module cc_bit_shifter
    import cc_pkg::*;
#(
    parameter int BIT_CLKS = 27
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] pair,
    output logic        level,
    output logic        busy
);
    localparam int CNT_W      = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam int SLOT_W     = $clog2(FRAME_SLOTS);
    localparam int FRAME_CLKS = FRAME_SLOTS * BIT_CLKS;
    localparam int LEN_W      = $clog2(FRAME_CLKS + 1);

    typedef struct packed {
        logic                   busy;
        logic [FRAME_SLOTS-1:0] frame;
        logic [SLOT_W-1:0]      slot;
        logic [CNT_W-1:0]       cnt;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.cnt == CNT_W'(BIT_CLKS - 1)) begin
                s_d.cnt   = '0;
                s_d.frame = s_q.frame >> 1;
                s_d.slot  = s_q.slot + 1'b1;
                if (s_q.slot == SLOT_W'(FRAME_SLOTS - 1)) s_d.busy = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (start) begin
            s_d.busy  = 1'b1;
            s_d.cnt   = '0;
            s_d.slot  = '0;
            s_d.frame = cc_frame(pair);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy  = s_q.busy;
    assign level = s_q.busy & s_q.frame[0];

    // run-length counter used only by the checks below
    logic [LEN_W-1:0] len_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      len_q <= '0;
        else if (s_q.busy) len_q <= len_q + 1'b1;
        else             len_q <= '0;
    end

    assert_line_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> len_q == LEN_W'(FRAME_CLKS));
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !level);
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/cc_line_inserter.sv
module cc_line_inserter
    import cc_pkg::*;
#(
    parameter int BIT_CLKS  = 27,
    parameter int LINE_W    = 10,
    parameter int ODD_LINE  = 21,
    parameter int EVEN_LINE = 284
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_wr,
    input  logic              cap_wr_field,
    input  logic [15:0]       cap_wr_pair,
    input  logic [1:0]        field_mode,
    input  logic              vbi_open,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_even,
    output logic              cc_level,
    output logic              cc_busy
);
    localparam int NFIELD = 2;
    localparam logic [LINE_W-1:0] CAP_LINE [NFIELD] = '{LINE_W'(ODD_LINE), LINE_W'(EVEN_LINE)};

    logic [15:0]       slot_pair [NFIELD];
    logic [NFIELD-1:0] take;
    logic              start;
    logic [15:0]       sel_pair;

    always_comb begin
        start = 1'b0;
        for (int f = 0; f < NFIELD; f++) begin
            take[f] = line_start && vbi_open && !cc_busy && field_mode[f]
                      && (field_even == f[0]) && (line_num == CAP_LINE[f]);
            start   = start | take[f];
        end
        sel_pair = slot_pair[field_even];
    end

    for (genvar f = 0; f < NFIELD; f++) begin : g_slot
        cc_pair_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cap_wr && (cap_wr_field == f[0])),
            .wr_pair  (cap_wr_pair),
            .take     (take[f]),
            .pair_out (slot_pair[f])
        );
    end

    cc_bit_shifter #(.BIT_CLKS(BIT_CLKS)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .pair  (sel_pair),
        .level (cc_level),
        .busy  (cc_busy)
    );

    assert_open_trigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_busy) |-> $past(line_start && vbi_open));
    assert_mode_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_busy) |-> $past(field_even ? field_mode[1] : field_mode[0]));
endmodule

// File: tb/cc_line_inserter_bench.sv
module cc_line_inserter_bench;
    localparam int BC    = 27;
    localparam int SLOTS = 33;
    localparam int TOTAL = SLOTS * BC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_wr = 1'b0, cap_wr_field = 1'b0;
    logic [15:0] cap_wr_pair = '0;
    logic [1:0]  field_mode = 2'b11;
    logic        vbi_open = 1'b1, line_start = 1'b0, field_even = 1'b0;
    logic [9:0]  line_num = '0;
    logic        cc_level, cc_busy;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cc_line_inserter u_cc_line_inserter (
        .clk(clk), .rst_n(rst_n), .cap_wr(cap_wr), .cap_wr_field(cap_wr_field),
        .cap_wr_pair(cap_wr_pair), .field_mode(field_mode), .vbi_open(vbi_open),
        .line_start(line_start), .line_num(line_num), .field_even(field_even),
        .cc_level(cc_level), .cc_busy(cc_busy));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_busy;
    int          m_cnt;
    bit          m_bits [SLOTS];
    bit          m_pv [2];
    logic [15:0] m_pd [2];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_pv[0] = 0; m_pv[1] = 0;
        end else begin
            bit st;
            st = line_start && vbi_open && !m_busy &&
                 ((!field_even && field_mode[0] && line_num == 21) ||
                  ( field_even && field_mode[1] && line_num == 284));
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == TOTAL) m_busy = 0;
            end
            if (st) begin
                logic [15:0] p;
                int fi;
                fi = field_even ? 1 : 0;
                p = m_pv[fi] ? m_pd[fi] : 16'h8080;
                m_pv[fi] = 0;
                for (int i = 0; i < 14; i++) m_bits[i] = (i % 2 == 0);
                m_bits[14] = 0; m_bits[15] = 0; m_bits[16] = 1;
                for (int i = 0; i < 16; i++) m_bits[17 + i] = p[i];
                m_busy = 1; m_cnt = 0;
            end
            if (cap_wr) begin
                m_pd[cap_wr_field ? 1 : 0] = cap_wr_pair;
                m_pv[cap_wr_field ? 1 : 0] = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit el;
            el = m_busy && m_bits[m_cnt / BC];
            chk(cc_busy == m_busy, "R6 busy vs model", cc_busy, m_busy);
            chk(cc_level == el, "R6/R12 level vs model", cc_level, el);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual %0d expected below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input bit f, input logic [15:0] d);
        cap_wr = 1; cap_wr_field = f; cap_wr_pair = d;
        @(negedge clk);
        cap_wr = 0;
    endtask

    task automatic emit(input bit f, input logic [9:0] ln, input bit sw, input bit swf,
                        input logic [15:0] swd, output bit got, output logic [32:0] bits);
        bit held;
        field_even = f; line_num = ln; line_start = 1;
        if (sw) begin cap_wr = 1; cap_wr_field = swf; cap_wr_pair = swd; end
        @(negedge clk);
        line_start = 0; cap_wr = 0;
        got = cc_busy; bits = '0; held = 1;
        if (got) begin
            for (int k = 0; k < TOTAL; k++) begin
                if (k % BC == BC / 2) bits[k / BC] = cc_level;
                if (!cc_busy) held = 0;
                @(negedge clk);
            end
            chk(held, "R6 busy held for whole line", held, 1);
            chk(!cc_busy, "R6 busy ends after 891 clocks", cc_busy, 0);
        end else begin
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic expect_line(input bit f, input logic [15:0] exp, input string req);
        bit got; logic [32:0] b;
        emit(f, f ? 10'd284 : 10'd21, 0, 0, 16'h0, got, b);
        chk(got, req, got, 1);
        chk(b[16:0] == 17'h11555, "R6 run-in and start bits", b[16:0], 17'h11555);
        chk(b[32:17] == exp, req, b[32:17], exp);
    endtask

    task automatic expect_none(input bit f, input logic [9:0] ln, input string req);
        bit got; logic [32:0] b;
        emit(f, ln, 0, 0, 16'h0, got, b);
        chk(!got, req, got, 0);
    endtask

    initial begin
        bit got; logic [32:0] b;
        repeat (3) @(negedge clk);
        chk(!cc_busy && !cc_level, "R1 reset outputs idle", {cc_busy, cc_level}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!cc_busy && !cc_level, "R1 idle after reset", {cc_busy, cc_level}, 0);

        expect_line(0, 16'h8080, "R1/R8 empty odd slot sends null");
        wr(0, 16'h4241);
        expect_line(0, 16'h4241, "R2/R7 odd pair on line 21");
        expect_line(0, 16'h8080, "R7/R8 pair consumed, null follows");

        wr(1, 16'h3713);
        wr(0, 16'h0102);
        wr(0, 16'hC3A5);
        expect_line(1, 16'h3713, "R3/R11 even pair on line 284");
        expect_line(0, 16'hC3A5, "R11 last odd write wins");

        wr(0, 16'h5A5A); wr(1, 16'h6B6B);
        field_mode = 2'b00;
        expect_none(0, 21, "R4 mode 00 blocks odd");
        expect_none(1, 284, "R4 mode 00 blocks even");
        field_mode = 2'b01;
        expect_none(1, 284, "R4 mode 01 blocks even");
        expect_none(0, 20, "R4 wrong line ignored");
        expect_none(1, 21, "R4 odd line number in even field ignored");
        field_mode = 2'b10;
        expect_none(0, 21, "R4 mode 10 blocks odd");
        expect_line(1, 16'h6B6B, "R4 mode 10 allows even");
        field_mode = 2'b11;
        vbi_open = 0;
        expect_none(0, 21, "R5 blanked VBI blocks insertion");
        vbi_open = 1;
        expect_line(0, 16'h5A5A, "R5 pending pair kept while blanked");

        // write and stray line start during an active line
        wr(0, 16'h1111);
        fork
            emit(0, 10'd21, 0, 0, 16'h0, got, b);
            begin
                repeat (100) @(negedge clk);
                wr(0, 16'h2222);
                repeat (100) @(negedge clk);
                field_even = 0; line_num = 10'd21; line_start = 1;
                @(negedge clk);
                line_start = 0;
            end
        join
        chk(b[32:17] == 16'h1111, "R9/R10 line unchanged by mid-line write and strobe",
            b[32:17], 16'h1111);
        chk(!cc_busy, "R10 no restart after ignored strobe", cc_busy, 0);
        expect_line(0, 16'h2222, "R9 mid-line write goes to next odd line");

        // write in the same cycle as the starting strobe
        emit(1, 10'd284, 1, 1, 16'h9C9C, got, b);
        chk(b[32:17] == 16'h8080, "R9 same-cycle write not in this line", b[32:17], 16'h8080);
        expect_line(1, 16'h9C9C, "R9 same-cycle write on next even line");

        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule